// File: doc/BRIEF.md
# NAND Ready Status Poller

This block waits for a raw NAND device to finish an internal operation. It does this by reading the device status instead of watching a ready/busy pin. After a start pulse it waits a short settling time and issues the status command (70h) once. It waits the command-to-data turnaround, then reads single status bytes, with a fixed pause between reads, until bit 6 reports ready. When the device is ready, the block issues the read-mode command (00h) so that page data can be fetched next.

The wait is bounded by a millisecond deadline given with the start pulse. The deadline is armed when the status command is accepted and is checked before every status read. If the device is still busy when the deadline is found expired, the block ends with a timeout. If the command engine reports an error on any request, the poll stops at once with a separate error code.

The block drives the request side of a byte-level NAND command engine. It offers one request at a time and holds it until the engine responds. All delay lengths are cycle counts derived from parameters that set the clock rate.

Top module: `nand_status_poller`

## Requirements
- R1: After reset `busy`, `done` and `req_valid` are low, and no request is offered while the block is idle.
- R2: The status command is a request of kind 0 (command) with byte 70h, offered no earlier than PRE_US microseconds of cycles after the start pulse.
- R3: The first status read is offered no earlier than WHR_CYC cycles after the status command is accepted.
- R4: The status command is issued exactly once per poll. Every poll is a data-in request (kind 3) of one byte with `req_bus8` high.
- R5: A status byte counts as ready only when bit 6 is set. All other bits of the byte are ignored.
- R6: After a ready byte, the block offers a command request with byte 00h. When that request is accepted, it pulses `done` with result 0 (ready).
- R7: After a busy status byte, the next status read is offered no earlier than GAP_US microseconds of cycles after the busy byte was accepted.
- R8: The deadline expires `timeout_ms` × US_PER_MS × CYC_PER_US cycles after the status command is accepted. It is checked before each status read. If it has expired, the block pulses `done` with result 1 (timeout) and issues no 00h command. A `timeout_ms` of 0 gives a timeout with no status read.
- R9: A ready byte ends the poll successfully even when its response arrives after the deadline has passed.
- R10: A response with `rsp_err` high ends the poll in the next cycle with `done` and result 2 (engine error). No further request is offered.
- R11: A start pulse while `busy` is high is ignored.
- R12: A request holds its kind and byte until it is answered. `done` is a single-cycle pulse given once per poll.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a poll (accepted when idle) |
| timeout_ms | input | TMO_W | Deadline in milliseconds, sampled when the status command is accepted |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse at the end of a poll |
| result | output | 2 | 0 ready, 1 timeout, 2 engine error; valid with `done` |
| req_valid | output | 1 | Request offered to the command engine |
| req_kind | output | 2 | 0 command, 1 address, 2 wait, 3 data-in |
| req_byte | output | 8 | Command byte for command requests |
| req_bus8 | output | 1 | Data-in uses the 8-bit path |
| rsp_valid | input | 1 | Engine completes the offered request in this cycle |
| rsp_err | input | 1 | Engine reports failure of the request |
| rsp_data | input | 8 | Byte read by a data-in request |

## Verification
The deadline expiry and the arrival of a status byte can fall in the same cycle. A read can also be in flight across the moment the deadline passes. The bench provokes this with a one-millisecond deadline and an engine response latency longer than that millisecond. It judges that a ready byte still finishes with result 0 and a 00h command. In the same setting, a busy byte must lead to result 1 after one further pause, with exactly one read made.

// File: rtl/nand_poll_pkg.sv
package nand_poll_pkg;

    typedef enum logic [1:0] {
        REQ_CMD  = 2'd0,
        REQ_ADDR = 2'd1,
        REQ_WAIT = 2'd2,
        REQ_DIN  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        RES_READY   = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_ENG_ERR = 2'd2
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_STAT_CMD,
        ST_TURN,
        ST_CHECK,
        ST_READ,
        ST_PAUSE,
        ST_MODE_CMD
    } poll_state_e;

    localparam logic [7:0] CMD_STATUS    = 8'h70;
    localparam logic [7:0] CMD_READ_MODE = 8'h00;
    localparam int         READY_BIT     = 6;

endpackage

// File: rtl/nps_interval_timer.sv
module nps_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nps_deadline.sv
module nps_deadline #(
    parameter int MS_CYC = 1000,
    parameter int TMO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [TMO_W-1:0] arm_ms,
    output logic             expired
);
    localparam int PW = (MS_CYC > 1) ? $clog2(MS_CYC) : 1;
    localparam logic [PW-1:0] PRE_TOP = PW'(MS_CYC - 1);

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [TMO_W-1:0] ms;
    } dl_t;

    dl_t dl_d, dl_q;

    always_comb begin
        dl_d = dl_q;
        if (arm) begin
            dl_d.pre = PRE_TOP;
            dl_d.ms  = arm_ms;
        end else if (dl_q.ms != '0) begin
            if (dl_q.pre == '0) begin
                dl_d.pre = PRE_TOP;
                dl_d.ms  = dl_q.ms - 1'b1;
            end else begin
                dl_d.pre = dl_q.pre - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= dl_d;
    end

    assign expired = (dl_q.ms == '0);
endmodule

// File: rtl/nand_status_poller.sv
module nand_status_poller #(
    parameter int CYC_PER_US = 250,
    parameter int PRE_US     = 1,
    parameter int GAP_US     = 10,
    parameter int WHR_CYC    = 30,
    parameter int US_PER_MS  = 1000,
    parameter int TMO_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMO_W-1:0] timeout_ms,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result,
    output logic             req_valid,
    output logic [1:0]       req_kind,
    output logic [7:0]       req_byte,
    output logic             req_bus8,
    input  logic             rsp_valid,
    input  logic             rsp_err,
    input  logic [7:0]       rsp_data
);
    import nand_poll_pkg::*;

    localparam int PRE_CYC = CYC_PER_US * PRE_US;
    localparam int GAP_CYC = CYC_PER_US * GAP_US;
    localparam int MS_CYC  = CYC_PER_US * US_PER_MS;
    localparam int MAX_A   = (PRE_CYC > GAP_CYC) ? PRE_CYC : GAP_CYC;
    localparam int TMR_MAX = (MAX_A > WHR_CYC) ? MAX_A : WHR_CYC;
    localparam int TW      = $clog2(TMR_MAX + 1);

    typedef struct packed {
        poll_state_e state;
        logic        done;
        result_e     result;
    } ctl_t;

    ctl_t          r_d, r_q;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          dl_arm, dl_expired;

    nps_interval_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    nps_deadline #(.MS_CYC(MS_CYC), .TMO_W(TMO_W)) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (dl_arm),
        .arm_ms  (timeout_ms),
        .expired (dl_expired)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        dl_arm    = 1'b0;
        req_valid = 1'b0;
        req_kind  = REQ_CMD;
        req_byte  = CMD_READ_MODE;
        req_bus8  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(PRE_CYC);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) r_d.state = ST_STAT_CMD;
            end
            ST_STAT_CMD: begin
                req_valid = 1'b1;
                req_byte  = CMD_STATUS;
                if (rsp_valid) begin
                    if (rsp_err) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_ENG_ERR;
                    end else begin
                        dl_arm    = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(WHR_CYC);
                        r_d.state = ST_TURN;
                    end
                end
            end
            ST_TURN: begin
                if (tmr_zero) r_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (dl_expired) begin
                    r_d.state  = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.result = RES_TIMEOUT;
                end else begin
                    r_d.state = ST_READ;
                end
            end
            ST_READ: begin
                req_valid = 1'b1;
                req_kind  = REQ_DIN;
                req_bus8  = 1'b1;
                if (rsp_valid) begin
                    if (rsp_err) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_ENG_ERR;
                    end else if (rsp_data[READY_BIT]) begin
                        r_d.state = ST_MODE_CMD;
                    end else begin
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(GAP_CYC);
                        r_d.state = ST_PAUSE;
                    end
                end
            end
            ST_PAUSE: begin
                if (tmr_zero) r_d.state = ST_CHECK;
            end
            ST_MODE_CMD: begin
                req_valid = 1'b1;
                req_byte  = CMD_READ_MODE;
                if (rsp_valid) begin
                    r_d.state  = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.result = rsp_err ? RES_ENG_ERR : RES_READY;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.done   <= 1'b0;
            r_q.result <= RES_READY;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.state != ST_IDLE);
    assign done   = r_q.done;
    assign result = r_q.result;
endmodule

// File: rtl/nand_status_poller_chk.sv
module nand_status_poller_chk #(
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [TMO_W-1:0] timeout_ms,
    input logic             busy,
    input logic             done,
    input logic [1:0]       result,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [7:0]       req_byte,
    input logic             req_bus8,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [7:0]       rsp_data
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R1

    AST_CMD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |-> (req_byte == 8'h70 || req_byte == 8'h00)); // R2

    AST_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |-> req_bus8); // R4

    AST_READY_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && !rsp_err && req_kind == 2'd3 && rsp_data[6])
        |=> (req_valid && req_kind == 2'd0 && req_byte == 8'h00)); // R6

    AST_BUSY_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && !rsp_err && req_kind == 2'd3 && !rsp_data[6])
        |=> (busy && !req_valid)); // R7

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && rsp_err) |=> (done && result == 2'd2 && !req_valid)); // R10

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_kind) && $stable(req_byte))); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
endmodule

bind nand_status_poller nand_status_poller_chk #(.TMO_W(TMO_W)) u_chk (.*);

// File: tb/nand_status_poller_tb.sv
module nand_status_poller_tb;
    localparam int CYC_PER_US = 2;
    localparam int PRE_US     = 1;
    localparam int GAP_US     = 10;
    localparam int WHR_CYC    = 6;
    localparam int US_PER_MS  = 50;
    localparam int TMO_W      = 8;
    localparam int PRE_C = CYC_PER_US * PRE_US;
    localparam int GAP_C = CYC_PER_US * GAP_US;
    localparam int MS_C  = CYC_PER_US * US_PER_MS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [TMO_W-1:0] timeout_ms = '0;
    logic             busy, done, req_valid, req_bus8;
    logic [1:0]       result, req_kind;
    logic [7:0]       req_byte;
    logic             rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [7:0]       rsp_data = 8'h00;

    always #2 clk = ~clk;

    nand_status_poller #(
        .CYC_PER_US(CYC_PER_US), .PRE_US(PRE_US), .GAP_US(GAP_US),
        .WHR_CYC(WHR_CYC), .US_PER_MS(US_PER_MS), .TMO_W(TMO_W)
    ) u_dut (.*);

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int done_cnt = 0;
    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    // responder state and log
    int ready_after = -1, err_at = -1, lat_g = 0, nreq = 0, rd_idx = 0;
    logic [1:0] lg_kind [64];
    logic [7:0] lg_byte [64];
    logic       lg_b8   [64];
    int         lg_start[64];
    int         lg_acc  [64];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_byte(input int idx, input int rdy, input logic [7:0] rnd);
        if (rdy >= 0 && idx == rdy) return rnd | 8'h40;
        return rnd & 8'hBF;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            while (req_valid && rst_n) begin
                automatic int idx = nreq;
                automatic logic [1:0] k = req_kind;
                if (idx < 64) begin
                    lg_kind[idx] = req_kind; lg_byte[idx] = req_byte;
                    lg_b8[idx] = req_bus8;   lg_start[idx] = cyc;
                end
                nreq++;
                repeat (lat_g) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_err   = (idx == err_at);
                rsp_data  = 8'h00;
                if (k == 2'd3) begin
                    rsp_data = status_byte(rd_idx, ready_after, 8'($urandom));
                    rd_idx++;
                end
                if (idx < 64) lg_acc[idx] = cyc;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
            end
        end
    end

    bit hung = 0;

    // T: deadline ms, K: ready read index (-1 never), E: failing request (-1 none)
    task automatic run_case(input int t, input int k, input int e, input int lat, input bit restart);
        int start_c, done_c, exp_res, exp_n, reads, guard, d0;
        nreq = 0; rd_idx = 0; ready_after = k; err_at = e; lat_g = lat;
        d0 = done_cnt;
        @(negedge clk);
        timeout_ms = TMO_W'(t);
        start = 1'b1; start_c = cyc;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin @(negedge clk); guard++; end
        if (!done) begin
            hung = 1;
            check(0, "watchdog", guard, 0);
            return;
        end
        done_c = cyc;
        // expected outcome from the requirements
        if (e >= 0 && k >= 0 && e <= k + 2) begin exp_res = 2; exp_n = e + 1; end
        else if (t == 0)                    begin exp_res = 1; exp_n = 1; end
        else if (k >= 0)                    begin exp_res = 0; exp_n = k + 3; end
        else                                begin exp_res = 1; exp_n = -1; end
        check(int'(result) == exp_res, exp_res == 2 ? "R10 result" :
              exp_res == 1 ? "R8 result" : "R6 result", int'(result), exp_res);
        if (exp_n >= 0) check(nreq == exp_n, "R10 request count", nreq, exp_n);
        else            check(nreq >= 2, "R8 reads made", nreq, 2);
        check(lg_kind[0] == 2'd0 && lg_byte[0] == 8'h70, "R2 status cmd", int'(lg_byte[0]), 8'h70);
        check(lg_start[0] - start_c >= PRE_C + 1 && lg_start[0] - start_c <= PRE_C + 3,
              "R2 settle", lg_start[0] - start_c, PRE_C + 2);
        reads = 0;
        for (int i = 1; i < nreq && i < 64; i++) begin
            if (lg_kind[i] == 2'd3) begin
                reads++;
                check(lg_b8[i] == 1'b1, "R4 8-bit poll", int'(lg_b8[i]), 1);
                if (i == 1) check(lg_start[1] - lg_acc[0] >= WHR_CYC + 2, "R3 turnaround",
                                  lg_start[1] - lg_acc[0], WHR_CYC + 2);
                else        check(lg_start[i] - lg_acc[i-1] >= GAP_C + 2, "R7 spacing",
                                  lg_start[i] - lg_acc[i-1], GAP_C + 2);
                if (t > 0)  check(lg_start[i] - lg_acc[0] <= t * MS_C + 2, "R8 read before expiry",
                                  lg_start[i] - lg_acc[0], t * MS_C);
            end else begin
                check(lg_kind[i] == 2'd0 && lg_byte[i] == 8'h00 && i == nreq - 1,
                      "R4 single status cmd / R6 mode cmd last", int'(lg_byte[i]), 0);
            end
        end
        if (exp_res == 0) check(lg_kind[nreq-1] == 2'd0 && lg_byte[nreq-1] == 8'h00,
                                "R6 read-mode cmd", int'(lg_byte[nreq-1]), 0);
        if (exp_res == 1 && t > 0) begin
            check(done_c - lg_acc[0] >= t * MS_C, "R8 deadline length", done_c - lg_acc[0], t * MS_C);
            check(done_c - lg_acc[0] <= t * MS_C + GAP_C + lat + 8, "R8 deadline late",
                  done_c - lg_acc[0], t * MS_C);
        end
        if (t == 0 && exp_res == 1) check(reads == 0, "R8 zero deadline no read", reads, 0);
        @(negedge clk);
        check(done_cnt - d0 == 1 && !done, "R12 single done pulse", done_cnt - d0, 1);
        check(!busy && !req_valid, "R1 idle after poll", int'(busy), 0);
        if (restart) check(nreq == exp_n, "R11 restart ignored", nreq, exp_n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !req_valid, "R1 reset state", int'({busy, done, req_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid, "R1 idle", int'(busy), 0);
        void'($urandom(32'd4242));

        run_case(2, 0, -1, 0, 0);   // R6 ready on first poll
        run_case(3, 4, -1, 1, 0);   // R5 R7 ready after busy bytes with random other bits
        run_case(1, -1, -1, 0, 0);  // R8 never ready
        run_case(0, -1, -1, 0, 0);  // R8 zero deadline
        run_case(1, 0, -1, 150, 0); // R9 ready answer after deadline
        run_case(1, -1, -1, 150, 0);// R9 busy answer after deadline -> timeout, one read
        check(nreq == 2, "R9 one read then timeout", nreq, 2);
        run_case(2, 3, 0, 0, 0);    // R10 error on status cmd
        run_case(2, 3, 2, 2, 0);    // R10 error on a poll
        run_case(2, 1, 3, 0, 0);    // R10 error on read-mode cmd
        run_case(2, 2, -1, 3, 1);   // R11 start while busy

        for (int n = 0; n < 40 && !hung; n++) begin
            automatic int t   = 1 + int'($urandom % 4);
            automatic int lat = int'($urandom % 4);
            automatic int mk  = (t * MS_C - 20) / (GAP_C + lat + 6);
            automatic int k   = ($urandom % 3 == 0) ? -1 : int'($urandom % (mk + 1));
            automatic int e   = (k >= 0 && $urandom % 4 == 0) ? int'($urandom % (k + 3)) : -1;
            run_case(t, k, e, lat, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule